// File: doc/BRIEF.md
# Injected Channel Conversion Sequencer

This block drives an external converter through a short list of channel numbers each time a trigger is accepted. Software programs one 32-bit configuration word holding a length code and four 5-bit channel slots. On a trigger the block takes a copy of that word and issues a start pulse with a channel number for each slot in use. After each start it waits for the converter's done pulse before it moves on. A one-cycle completion pulse marks the end of the list.

The list is right-aligned. A shorter list starts at a later slot and always finishes on slot 4. Slots that hold a channel number outside 0..18 are skipped without a start pulse, and a one-cycle error flag is raised for each one. Every output is registered, and the configuration word reads back on a registered port.

Top module: `inj_seq_top`

## Requirements
- R1: The configuration word resets to zero. A write stores bits 21:0 and forces bits 31:22 to zero. The stored value appears on `cfg_rdata` one cycle after the write. Slot 1 sits in bits 4:0, slot 2 in bits 9:5, slot 3 in bits 14:10, slot 4 in bits 19:15 and the length code in bits 21:20.
- R2: Length code L (0..3) gives L+1 slot visits per trigger.
- R3: Slots are visited in ascending order, from slot 4-L to slot 4.
- R4: A valid slot produces `conv_start` high for exactly one cycle, two cycles after the trigger or done that led to it, with the slot's channel on `conv_chan`. No further start is issued until `conv_done` is seen.
- R5: The configuration is captured when the trigger is accepted. A write made during a running sequence only affects the next trigger.
- R6: `busy` rises the cycle after an accepted trigger and falls with the completion pulse. A trigger seen while `busy` is high has no effect.
- R7: A slot whose channel is above 18 produces no start. Instead, `chan_err` pulses for one cycle and the sequence moves to the next slot in the following cycle.
- R8: `seq_done` pulses for one cycle, one cycle after the final slot's done, or after the final slot is skipped.
- R9: A trigger after reset converts channel 0 exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| trig | input | 1 | Sequence trigger |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 5 | Channel for the converter |
| conv_done | input | 1 | Converter completion pulse |
| busy | output | 1 | Sequence running |
| chan_err | output | 1 | One-cycle invalid-channel flag |
| seq_done | output | 1 | One-cycle sequence-complete pulse |

## Verification
The assertions assume that the converter answers each start with a single one-cycle done pulse, and never raises done while no conversion is outstanding. The bench's converter stub delivers exactly one done per start, after a latency chosen for each test, so this assumption always holds. Triggers and writes are still sent freely during running sequences, because the requirements cover those cases.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_t;
endpackage

// File: rtl/inj_cfg_reg.sv
module inj_cfg_reg #(
  parameter int DW   = 32,
  parameter int USED = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] MASK = {{(DW-USED){1'b0}}, {USED{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (we) rdata <= wdata & MASK;
  end
endmodule

// File: rtl/inj_seq_ctrl.sv
module inj_seq_ctrl
  import inj_seq_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CHW   = 5,
  parameter int LENW  = 2,
  parameter int MAXCH = 18,
  localparam int USED = SLOTS*CHW + LENW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [USED-1:0] cfg,
  input  logic            trig,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CHW-1:0]  conv_chan,
  output logic            busy,
  output logic            chan_err,
  output logic            seq_done
);
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDXW-1:0] LAST = IDXW'(SLOTS-1);

  logic [CHW-1:0]  slot_cfg [SLOTS];
  logic [CHW-1:0]  slot_q   [SLOTS];
  logic [LENW-1:0] len_code;
  logic [IDXW-1:0] idx_q, first_idx;
  logic [CHW-1:0]  cur_chan;
  logic            cur_bad, at_last;
  seq_state_t      state;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    assign slot_cfg[gi] = cfg[gi*CHW +: CHW];
  end

  assign len_code  = cfg[SLOTS*CHW +: LENW];
  assign first_idx = LAST - IDXW'(len_code);
  assign cur_chan  = slot_q[idx_q];
  assign cur_bad   = cur_chan > CHW'(MAXCH);
  assign at_last   = idx_q == LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx_q      <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      chan_err   <= 1'b0;
      seq_done   <= 1'b0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      chan_err   <= 1'b0;
      seq_done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (trig) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_cfg[i];
            idx_q <= first_idx;
            busy  <= 1'b1;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cur_bad) begin
            chan_err <= 1'b1;
            if (at_last) begin
              seq_done <= 1'b1;
              busy     <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            conv_start <= 1'b1;
            conv_chan  <= cur_chan;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            if (at_last) begin
              seq_done <= 1'b1;
              busy     <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/inj_seq_top.sv
module inj_seq_top #(
  parameter int DW    = 32,
  parameter int SLOTS = 4,
  parameter int CHW   = 5,
  parameter int LENW  = 2,
  parameter int MAXCH = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           trig,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  output logic           busy,
  output logic           chan_err,
  output logic           seq_done
);
  localparam int USED = SLOTS*CHW + LENW;

  inj_cfg_reg #(.DW(DW), .USED(USED)) u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata)
  );

  inj_seq_ctrl #(.SLOTS(SLOTS), .CHW(CHW), .LENW(LENW), .MAXCH(MAXCH)) u_ctrl (
    .clk(clk), .rst(rst), .cfg(cfg_rdata[USED-1:0]), .trig(trig),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .busy(busy), .chan_err(chan_err), .seq_done(seq_done)
  );
endmodule

// File: rtl/inj_seq_checker.sv
module inj_seq_checker #(
  parameter int DW    = 32,
  parameter int CHW   = 5,
  parameter int USED  = 22,
  parameter int MAXCH = 18
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  cfg_rdata,
  input logic           trig,
  input logic           conv_start,
  input logic [CHW-1:0] conv_chan,
  input logic           conv_done,
  input logic           busy,
  input logic           chan_err,
  input logic           seq_done
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DW-1:USED] == '0);
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  p_start_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);
  p_idle_trig_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && trig) |=> busy);
  p_valid_chan_r7: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_chan <= CHW'(MAXCH));
  p_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(chan_err && conv_start));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> $fell(busy));
endmodule

bind inj_seq_top inj_seq_checker #(
  .DW(DW), .CHW(CHW), .USED(SLOTS*CHW + LENW), .MAXCH(MAXCH)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .trig(trig),
  .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
  .busy(busy), .chan_err(chan_err), .seq_done(seq_done)
);

// File: tb/tb_inj_seq_top.sv
`timescale 1ns/1ps
module tb_inj_seq_top;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0, trig = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        conv_start, conv_done, busy, chan_err, seq_done;
  logic [4:0]  conv_chan;

  int total = 0, bad = 0, cycles = 0, lat = 2, cnt = 0;
  int got[$];

  always #2.5 clk = ~clk;

  inj_seq_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig(trig), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .busy(busy),
    .chan_err(chan_err), .seq_done(seq_done)
  );

  // converter stub: one done pulse per start, lat cycles later
  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (conv_start) cnt <= lat;
    else if (cnt != 0) cnt <= cnt - 1;
  end
  assign conv_done = (cnt == 1);

  always @(posedge clk) if (!rst && conv_start) got.push_back(int'(conv_chan));

  // behavioural reference
  int m_reg = 0, m_ph = 0, m_chan = 0;
  bit m_start = 0, m_busy = 0, m_err = 0, m_done = 0;
  int q[$];
  always @(posedge clk) begin
    if (rst) begin
      m_reg = 0; m_ph = 0; m_chan = 0; m_start = 0; m_busy = 0;
      m_err = 0; m_done = 0; q.delete();
    end else begin
      m_start = 0; m_err = 0; m_done = 0;
      if (m_ph == 0) begin
        if (trig) begin
          int l;
          l = (m_reg >> 20) & 3;
          q.delete();
          for (int s = 3 - l; s <= 3; s++) q.push_back((m_reg >> (5*s)) & 31);
          m_busy = 1; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (q[0] > 18) begin
          m_err = 1; void'(q.pop_front());
          if (q.size() == 0) begin m_done = 1; m_busy = 0; m_ph = 0; end
        end else begin
          m_start = 1; m_chan = q[0]; m_ph = 2;
        end
      end else begin
        if (conv_done) begin
          void'(q.pop_front());
          if (q.size() == 0) begin m_done = 1; m_busy = 0; m_ph = 0; end
          else m_ph = 1;
        end
      end
      if (cfg_we) m_reg = cfg_wdata & 32'h003F_FFFF;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    cycles++;
    chk(cfg_rdata == m_reg,    "R1 rdata", cfg_rdata, m_reg);
    chk(conv_start == m_start, "R4 start", conv_start, m_start);
    if (m_start) chk(conv_chan == m_chan, "R3 chan", conv_chan, m_chan);
    chk(busy == m_busy,        "R6 busy", busy, m_busy);
    chk(chan_err == m_err,     "R7 err", chan_err, m_err);
    chk(seq_done == m_done,    "R8 done", seq_done, m_done);
  end

  always @(negedge clk) if (cycles > 20000) begin
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] mk(int l, int s1, int s2, int s3, int s4);
    return {10'b0, 2'(l), 5'(s4), 5'(s3), 5'(s2), 5'(s1)};
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int e[$], input string req);
    got.delete();
    pulse_trig();
    wait_idle();
    chk(got.size() == e.size(), {req, " count"}, got.size(), e.size());
    for (int i = 0; i < e.size() && i < got.size(); i++)
      chk(got[i] == e[i], {req, " order"}, got[i], e[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cfg_rdata == 0 && !busy, "R1 reset", cfg_rdata, 0);
    // R9: default word converts channel 0 once
    run('{0}, "R9");
    // R2 R3: each length code
    wr(mk(3, 5, 6, 7, 8));  lat = 2; run('{5, 6, 7, 8}, "R3 len3");
    wr(mk(2, 5, 6, 7, 8));  lat = 1; run('{6, 7, 8}, "R2 len2");
    wr(mk(1, 5, 6, 7, 8));  lat = 4; run('{7, 8}, "R2 len1");
    wr(mk(0, 5, 6, 7, 8));  lat = 3; run('{8}, "R2 len0");
    wr(mk(3, 0, 18, 1, 17)); lat = 1; run('{0, 18, 1, 17}, "R3 edge");
    // R1: reserved bits dropped
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h003F_FFFF, "R1 reserved", cfg_rdata, 32'h003F_FFFF);
    // R7: all slots invalid -> no starts
    run('{}, "R7 allbad");
    wr(mk(3, 3, 19, 4, 31)); lat = 2; run('{3, 4}, "R7 mixed");
    // R5 R6: write and retrigger during a run
    wr(mk(3, 1, 2, 3, 4)); lat = 6;
    got.delete();
    pulse_trig();
    @(negedge clk); cfg_we = 1; cfg_wdata = mk(0, 0, 0, 0, 9);
    @(negedge clk); cfg_we = 0; trig = 1;
    @(negedge clk); trig = 0;
    wait_idle();
    chk(got.size() == 4, "R5 captured count", got.size(), 4);
    if (got.size() == 4) chk(got[3] == 4, "R6 retrig ignored", got[3], 4);
    lat = 2; run('{9}, "R5 next");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule